// File: doc/BRIEF.md
# Capacitive Divider Conversion Sequencer

This block is the digital controller for a successive-approximation converter used to sense capacitance. It runs each conversion as a set of timed phases. An optional pre-charge phase forces the hold capacitor and the selected pin to opposite or matching rails. An optional acquisition phase then connects the pin to the capacitor so that the two share charge. Last comes a 10-bit binary search that takes one comparator decision per clock. The analog parts, the comparator and the register file sit outside the block, so every control bit and every result is a plain port.

A sequence starts from a software go pulse or from a hardware trigger. The busy output stays high from the start until the last result is stored. With double sampling enabled, one start gives two complete sequences, two cycles apart. The second sequence can run with all drive polarities inverted, which lets the two results be subtracted to reject common-mode error. Software can cut a conversion short. The bits already decided are then kept, and the bits not yet reached are filled with the last decided bit.

Top module: `cvd_sequencer`

## Requirements
- R1: After reset the block is idle: busy, irq, mux_en, both hold shorts, pin_drv_en and out_drv_en are 0, and res0 and res1 are 0.
- R2: In idle with enable high, a go_set or trigger pulse starts a sequence, and busy is 1 from the next cycle until the sequence ends. A start pulse while enable is low has no effect. A go_set pulse while busy has no effect on the timing or the results.
- R3: Pre-charge lasts pre_len cycles and is skipped when pre_len is 0. During it, hold_short_vdd is 1 when the effective internal polarity is 1, hold_short_vss is 1 when that polarity is 0, pin_drv_en is 1, pin_drv_val equals the effective external polarity, and mux_en is 0.
- R4: out_drv_en is 1 exactly during pre-charge with out_ovr_en set, and out_drv_val equals the effective internal polarity.
- R5: Acquisition follows pre-charge, or follows the start directly when pre-charge is skipped. It lasts acq_len cycles, is skipped when acq_len is 0, and has mux_en 1 with no shorts or pin drive.
- R6: Conversion lasts 10 cycles with mux_en 1. cmp_in sampled at the end of conversion cycle k (k = 0 first) becomes result bit 9-k.
- R7: When the final conversion completes, busy falls and irq rises at the same edge, and the result is stored. irq stays 1 until an irq_clr pulse.
- R8: A go_clr pulse while busy returns the block to idle at the next edge without raising irq. If the pulse comes in conversion cycle k, the current result register takes the k decided bits, with every lower bit equal to the last decided bit (all zero when k is 0). In any other phase the result registers are unchanged.
- R9: Driving enable low while busy returns the block to idle at the next edge, with no result written and no irq.
- R10: With dbl_en set, the first result goes to res0. After 2 gap cycles with busy held, a second full pre-charge, acquisition and conversion stores its result in res1. irq rises only after the second result. Without dbl_en, res1 is never written.
- R11: With dbl_en and inv_en set, from the end of the first conversion until the sequence ends, the effective internal, external and guard polarities are the inverses of int_pol, ext_pol and guard_pol. Otherwise they equal those inputs. guard_val always shows the effective guard polarity.
- R12: A go_clr pulse in the final conversion cycle wins over completion: irq stays 0 and bit 0 is filled from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Module enable |
| go_set | input | 1 | Software start pulse |
| go_clr | input | 1 | Software abort pulse |
| trigger | input | 1 | Hardware start pulse |
| irq_clr | input | 1 | Clears the interrupt flag |
| pre_len | input | 7 | Pre-charge length in cycles, 0 skips |
| acq_len | input | 7 | Acquisition length in cycles, 0 skips |
| int_pol | input | 1 | Hold capacitor short polarity |
| ext_pol | input | 1 | Channel pin drive polarity |
| guard_pol | input | 1 | Guard output polarity |
| out_ovr_en | input | 1 | Enables the dedicated output pin drive in pre-charge |
| dbl_en | input | 1 | Double-sample mode |
| inv_en | input | 1 | Invert polarities for the second sample |
| cmp_in | input | 1 | Comparator decision |
| busy | output | 1 | Sequence in progress (go status) |
| irq | output | 1 | Completion interrupt flag |
| hold_short_vdd | output | 1 | Short hold capacitor to supply |
| hold_short_vss | output | 1 | Short hold capacitor to ground |
| pin_drv_en | output | 1 | Override drive on channel pin |
| pin_drv_val | output | 1 | Level for channel pin override |
| out_drv_en | output | 1 | Override drive on dedicated output pin |
| out_drv_val | output | 1 | Level for dedicated output override |
| guard_val | output | 1 | Effective guard polarity |
| mux_en | output | 1 | Analog multiplexer closed |
| res0 | output | 10 | First result |
| res1 | output | 10 | Second result |

## Verification
An abort and the final conversion decision can land in the same cycle, and only one of them may take effect. The bench pulses go_clr in each of the ten conversion cycles in turn, including the last one, in both the first and the second sample. It checks that busy drops with irq still low and that the stored word has exactly the decided bits, with the rest filled from the last decided bit. A start pulse that arrives while a sequence is running is also sent at a chosen mid-sequence cycle, and the bench judges it by the unchanged phase timing and results.

// File: rtl/cvd_sequencer.sv
module cvd_sequencer #(
  parameter int RES_W = 10,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic             trigger,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] pre_len,
  input  logic [CNT_W-1:0] acq_len,
  input  logic             int_pol,
  input  logic             ext_pol,
  input  logic             guard_pol,
  input  logic             out_ovr_en,
  input  logic             dbl_en,
  input  logic             inv_en,
  input  logic             cmp_in,
  output logic             busy,
  output logic             irq,
  output logic             hold_short_vdd,
  output logic             hold_short_vss,
  output logic             pin_drv_en,
  output logic             pin_drv_val,
  output logic             out_drv_en,
  output logic             out_drv_val,
  output logic             guard_val,
  output logic             mux_en,
  output logic [RES_W-1:0] res0,
  output logic [RES_W-1:0] res1
);
  localparam int IDX_W = $clog2(RES_W);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACQ, S_CONV, S_GAP} st_t;

  st_t              state, first_st;
  logic [CNT_W-1:0] cnt, first_cnt;
  logic [IDX_W-1:0] bidx;
  logic [RES_W-1:0] sar, sh, fillm, partial;
  logic             second;

  assign first_st  = (pre_len != '0) ? S_PRE : (acq_len != '0) ? S_ACQ : S_CONV;
  assign first_cnt = (pre_len != '0) ? pre_len : acq_len;

  assign sh      = sar >> bidx;
  assign fillm   = ~(({RES_W{1'b1}} << bidx) << 1);
  assign partial = sh[1] ? (sar | fillm) : sar;

  logic inv, ip, pre;
  assign inv = second & inv_en;
  assign ip  = int_pol ^ inv;
  assign pre = (state == S_PRE);

  assign busy           = (state != S_IDLE);
  assign hold_short_vdd = pre & ip;
  assign hold_short_vss = pre & ~ip;
  assign pin_drv_en     = pre;
  assign pin_drv_val    = ext_pol ^ inv;
  assign out_drv_en     = pre & out_ovr_en;
  assign out_drv_val    = ip;
  assign guard_val      = guard_pol ^ inv;
  assign mux_en         = (state == S_ACQ) || (state == S_CONV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sar    <= '0;
      second <= 1'b0;
      irq    <= 1'b0;
      res0   <= '0;
      res1   <= '0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (state == S_IDLE) begin
        if (enable && (go_set || trigger)) begin
          state  <= first_st;
          cnt    <= first_cnt;
          bidx   <= IDX_W'(RES_W-1);
          sar    <= '0;
          second <= 1'b0;
        end
      end else if (!enable) begin
        state  <= S_IDLE;
        second <= 1'b0;
      end else if (go_clr) begin
        if (state == S_CONV) begin
          if (second) res1 <= partial;
          else        res0 <= partial;
        end
        state  <= S_IDLE;
        second <= 1'b0;
      end else begin
        case (state)
          S_PRE: begin
            if (cnt == CNT_W'(1)) begin
              state <= (acq_len != '0) ? S_ACQ : S_CONV;
              cnt   <= acq_len;
            end else cnt <= cnt - 1'b1;
          end
          S_ACQ: begin
            if (cnt == CNT_W'(1)) state <= S_CONV;
            else                  cnt   <= cnt - 1'b1;
          end
          S_CONV: begin
            sar[bidx] <= cmp_in;
            if (bidx == '0) begin
              if (second) res1 <= {sar[RES_W-1:1], cmp_in};
              else        res0 <= {sar[RES_W-1:1], cmp_in};
              if (!second && dbl_en) begin
                state  <= S_GAP;
                cnt    <= CNT_W'(2);
                second <= 1'b1;
              end else begin
                state  <= S_IDLE;
                second <= 1'b0;
                irq    <= 1'b1;
              end
            end else bidx <= bidx - 1'b1;
          end
          S_GAP: begin
            if (cnt == CNT_W'(1)) begin
              state <= first_st;
              cnt   <= first_cnt;
              bidx  <= IDX_W'(RES_W-1);
              sar   <= '0;
            end else cnt <= cnt - 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cvd_sequencer_chk.sv
module cvd_sequencer_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             go_set,
  input logic             go_clr,
  input logic             trigger,
  input logic             out_ovr_en,
  input logic             dbl_en,
  input logic             busy,
  input logic             irq,
  input logic             hold_short_vdd,
  input logic             hold_short_vss,
  input logic             pin_drv_en,
  input logic             out_drv_en,
  input logic             mux_en,
  input logic [RES_W-1:0] res1
);
  // R3
  mux_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mux_en && (hold_short_vdd || hold_short_vss || pin_drv_en)));

  // R4
  out_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_drv_en |-> (pin_drv_en && out_ovr_en));

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && (go_set || trigger)));

  // R7
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_clr && enable) |=> (!busy && !$rose(irq)));

  // R9
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && busy) |=> (!busy && !$rose(irq)));

  // R10
  res1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res1) |-> $past(dbl_en));
endmodule

bind cvd_sequencer cvd_sequencer_chk #(.RES_W(RES_W)) i_chk (.*);

// File: tb/test_cvd_sequencer.sv
`timescale 1ns/1ps
module test_cvd_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, go_set = 1'b0, go_clr = 1'b0, trigger = 1'b0, irq_clr = 1'b0;
  logic [6:0] pre_len = '0, acq_len = '0;
  logic int_pol = 0, ext_pol = 0, guard_pol = 0, out_ovr_en = 0, dbl_en = 0, inv_en = 0, cmp_in = 0;
  logic busy, irq, hold_short_vdd, hold_short_vss, pin_drv_en, pin_drv_val;
  logic out_drv_en, out_drv_val, guard_val, mux_en;
  logic [9:0] res0, res1;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cvd_sequencer i_cvd_sequencer (.*);

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [9:0] part(logic [9:0] p, int k);
    logic [9:0] r;
    for (int i = 0; i < 10; i++)
      r[i] = (9 - i < k) ? p[i] : ((k == 0) ? 1'b0 : p[10-k]);
    return r;
  endfunction

  task automatic run_seq(int pre, int acq, logic [9:0] p0, logic [9:0] p1, bit dbl, bit inv,
                         bit trig, int abort_at, int poke, logic [3:0] pol);
    logic [9:0] old0, old1, e0, e1;
    int L, total;
    old0 = res0; old1 = res1;
    @(negedge clk);
    pre_len = 7'(pre); acq_len = 7'(acq); dbl_en = dbl; inv_en = inv;
    {out_ovr_en, guard_pol, ext_pol, int_pol} = pol;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    if (trig) trigger = 1'b1; else go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0; trigger = 1'b0;
    L = pre + acq + 10;
    total = dbl ? 2 * L + 2 : L;
    for (int c = 0; c < total; c++) begin
      int s, off, ph, k;
      bit i2, ipe;
      logic [9:0] exp_v, got_v;
      string req;
      if (c < L) begin s = 0; off = c; end
      else if (c < L + 2) begin s = 2; off = 0; end
      else begin s = 1; off = c - L - 2; end
      if (s == 2) ph = 3;
      else if (off < pre) ph = 0;
      else if (off < pre + acq) ph = 1;
      else ph = 2;
      k = off - pre - acq;
      i2 = (s != 0) && inv;
      ipe = int_pol ^ i2;
      exp_v = {1'b1, 1'b0, (ph == 1 || ph == 2), (ph == 0) && ipe, (ph == 0) && !ipe,
               (ph == 0), ext_pol ^ i2, (ph == 0) && out_ovr_en, ipe, guard_pol ^ i2};
      got_v = {busy, irq, mux_en, hold_short_vdd, hold_short_vss, pin_drv_en, pin_drv_val,
               out_drv_en, out_drv_val, guard_val};
      req = (ph == 0) ? "R3 R4" : (ph == 1) ? "R5" : (ph == 2) ? "R6" : "R10";
      if (i2) req = {req, " R11"};
      check(req, 16'(got_v), 16'(exp_v));
      cmp_in = (ph == 2) ? ((s == 1) ? p1[9-k] : p0[9-k]) : 1'b0;
      go_set = (c == poke);
      if (c == abort_at) begin
        go_clr = 1'b1;
        @(negedge clk);
        go_clr = 1'b0; go_set = 1'b0;
        e0 = (s != 0) ? p0 : old0;
        e1 = old1;
        if (ph == 2 && s == 0) e0 = part(p0, k);
        if (ph == 2 && s == 1) e1 = part(p1, k);
        check((ph == 2 && k == 9) ? "R12" : "R8", 16'({busy, irq}), 16'b0);
        check("R8 res0", 16'(res0), 16'(e0));
        check("R8 res1", 16'(res1), 16'(e1));
        return;
      end
      @(negedge clk);
    end
    go_set = 1'b0;
    check("R7 done", 16'({busy, irq}), 16'b01);
    check("R7 res0", 16'(res0), 16'(p0));
    check("R10 res1", 16'(res1), 16'(dbl ? p1 : old1));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 ctl", 16'({busy, irq, mux_en, hold_short_vdd, hold_short_vss, pin_drv_en, out_drv_en}), 16'b0);
    check("R1 res", 16'({res0, res1}), 16'b0);
    check("R1 res1", 16'(res1), 16'b0);

    go_set = 1'b1; trigger = 1'b1;
    @(negedge clk);
    go_set = 1'b0; trigger = 1'b0;
    check("R2 disabled start", 16'(busy), 16'b0);
    enable = 1'b1;

    for (int i = 0; i < 18; i++) begin
      logic [9:0] p;
      int pv [3] = '{0, 1, 3};
      int av [3] = '{0, 1, 2};
      p = 10'((i * 337 + 5) & 1023);
      run_seq(pv[i % 3], av[(i / 3) % 3], p, ~p ^ 10'(i), bit'(i / 9), bit'(i[0] ^ i[2]),
              bit'(i[1]), -1, (i % 4 == 0) ? 2 : -1, 4'(i * 5));
      repeat (2) @(negedge clk);
      check("R7 irq held", 16'(irq), 16'b1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R7 irq clear", 16'(irq), 16'b0);
    end

    for (int k = 0; k < 10; k++) begin
      run_seq(2, 1, 10'b1011001110, 10'b0, 1'b0, 1'b0, 1'b0, 3 + k, -1, 4'b0101);
      run_seq(0, 0, 10'b0100110001, 10'b1101100101, 1'b1, 1'b1, 1'b1, 12 + k, -1, 4'b1010);
    end
    run_seq(2, 2, 10'h2aa, 10'h155, 1'b0, 1'b0, 1'b0, 0, -1, 4'b1111);
    run_seq(2, 2, 10'h2aa, 10'h155, 1'b0, 1'b0, 1'b0, 3, -1, 4'b0000);
    run_seq(1, 1, 10'h3c3, 10'h0f0, 1'b1, 1'b1, 1'b0, 12, -1, 4'b0011);

    run_seq(1, 1, 10'h3ff, 10'h000, 1'b0, 1'b0, 1'b0, -1, -1, 4'b0);
    @(negedge clk);
    pre_len = 7'd2; acq_len = 7'd2; dbl_en = 1'b0;
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    cmp_in = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 halt", 16'({busy, irq}), 16'b01);
    check("R9 res0", 16'(res0), 16'h3ff);
    enable = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule